// File: doc/BRIEF.md
# Banked Interrupt-Interface Control Register Access Unit

This block holds a 64-bit control register for a processor's interrupt interface and decides, for every read or write request, what happens to it. The request carries the privilege level of the requester (0 to 3) and the effective security state of the access. The unit applies an ordered chain of permission checks before any storage is touched. Each request ends in one of four outcomes. It can complete on a bank. It can be redirected to a virtual copy that lives outside this block. It can return an undefined result. It can raise a trap with a target level and a syndrome class.

When the block is built with the most privileged level present (`HAS_L3 = 1`), the register exists twice, one secure copy and one non-secure copy. The request's security tag picks the copy. Without that level there is a single copy.

A global security-disable input decides whether the preemption-grouping bit (bit 0) and the distribution-hint bit (bit 6) take writes. The capability fields are constants set by parameters.

Top module: `bca_top`

## Requirements
- R1: Bits 63:20, 17:16, 7 and 5:2 of every returned value are zero, and writes to them have no effect.
- R2: The capability fields read back as these constants, whatever is written to them:
  - bit 19 = `EXT_RANGE`
  - bit 18 = `WIDE_TARGET`
  - bit 15 = `AFF3_OK`
  - bit 14 = `LOCAL_SERR`
  - bits 13:11 = 0b001 when `ID24` is 1 (24 identifier bits), 0b000 otherwise (16 bits)
  - bits 10:8 = `PRI_BITS`-1
- R3: With `HAS_L3 = 1`, `reqNonSecure` selects the bank: 0 is the secure copy and 1 is the non-secure copy. A write to one bank leaves the other bank unchanged.
- R4: Bit 1 (end-of-interrupt mode) is writable in each bank on every completed write, and it resets to 0.
- R5: With `HAS_L3 = 1`, bits 6 and 0 take the written value only when `secDisable` is 1. When `secDisable` is 0 they keep their value. Both reset to 0.
- R6: A request at level 0 always returns UNDEF.
- R7: At level 1 the checks are applied in this order, and the first one that matches decides the outcome:
  - `sreL1` = 0 gives TRAP to level 1.
  - `l2Enabled` and `l2TrapCtl` give TRAP to level 2.
  - `l2Enabled` with `l2FiqRoute` or `l2IrqRoute` gives VIRTUAL.
  - `irqToL3` and `fiqToL3` both set give UNDEF if `dbgUndef` is 1, otherwise TRAP to level 3.
  - If no check matches, the access completes (OK).
- R8: At level 2 the checks are applied in this order:
  - `sreL2` = 0 gives TRAP to level 2.
  - Both routings to level 3 give UNDEF if `dbgUndef` is 1, otherwise TRAP to level 3.
  - If neither matches, the result is OK.

  At level 3, `sreL3` = 0 gives TRAP to level 3, otherwise OK.
- R9: A TRAP response carries syndrome class 0x18. Every other response carries syndrome 0.
- R10: At levels 1 and 2, `undefPrio` together with both routings to level 3 returns UNDEF ahead of every other check.
- R11: The response appears one cycle after the request.
  - `rspValid` is high for exactly that cycle.
  - `rspKind` is encoded OK=0, VIRTUAL=1, UNDEF=2, TRAP=3.
  - `rspTarget` is the trap level, and 0 for outcomes that are not traps.
  - On OK, `rdData` is the selected bank's value before the access. Otherwise `rdData` is 0.
  - An outcome other than OK changes no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLevel | input | 2 | Privilege level of requester |
| reqNonSecure | input | 1 | Effective non-secure state of the access |
| wrData | input | 64 | Write data |
| secDisable | input | 1 | Global security-disable |
| sreL1 | input | 1 | System-register enable for level 1 |
| sreL2 | input | 1 | System-register enable for level 2 |
| sreL3 | input | 1 | System-register enable for level 3 |
| l2Enabled | input | 1 | Level 2 is enabled for this access |
| l2TrapCtl | input | 1 | Level-2 trap-control bit for this register |
| l2FiqRoute | input | 1 | Level-2 FIQ routing bit |
| l2IrqRoute | input | 1 | Level-2 IRQ routing bit |
| irqToL3 | input | 1 | IRQ routed to level 3 |
| fiqToL3 | input | 1 | FIQ routed to level 3 |
| dbgUndef | input | 1 | Debug condition turning a level-3 trap into UNDEF |
| undefPrio | input | 1 | High-priority undefined condition |
| rspValid | output | 1 | Response valid |
| rspKind | output | 2 | Outcome: OK=0, VIRTUAL=1, UNDEF=2, TRAP=3 |
| rspTarget | output | 2 | Trap target level |
| rspSyndrome | output | 6 | Syndrome class |
| rdData | output | 64 | Read data |

## Verification
The hardest situations to reach are those where several permission conditions hold at once. Only the first one in the chain may decide the outcome, and the state it blocks must be shown untouched.

The bench sets up the context signals so that two or more checks match at the same time. It then removes them one at a time, walking down the chain. After every blocked write it reads the bank back through an allowed level-3 access, which proves that no stored bit moved. Bank independence is shown the same way: each copy is written with a different pattern, and both are read back.

// File: rtl/bca_pkg.sv
package bca_pkg;
  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_VIRT  = 2'd1,
    RSP_UNDEF = 2'd2,
    RSP_TRAP  = 2'd3
  } rspKind_e;

  typedef struct packed {
    logic accept;   // a request was taken this cycle
    logic okAccess; // the decision lets the access reach the bank
    logic wrEn;     // commit the write to the selected bank
    logic bankSel;  // 1 = non-secure copy
  } bankStrobe_t;

  localparam logic [5:0] TRAP_CLASS = 6'h18;
endpackage

// File: rtl/bca_decide.sv
module bca_decide
  import bca_pkg::*;
#(
  parameter bit HAS_L3 = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqLevel,
  input  logic        reqNonSecure,
  input  logic        sreL1,
  input  logic        sreL2,
  input  logic        sreL3,
  input  logic        l2Enabled,
  input  logic        l2TrapCtl,
  input  logic        l2FiqRoute,
  input  logic        l2IrqRoute,
  input  logic        irqToL3,
  input  logic        fiqToL3,
  input  logic        dbgUndef,
  input  logic        undefPrio,
  output bankStrobe_t strobe,
  output logic        rspValid,
  output logic [1:0]  rspKind,
  output logic [1:0]  rspTarget,
  output logic [5:0]  rspSyndrome
);
  rspKind_e   kindD;
  logic [1:0] tgtD;
  logic       bothRouted;
  logic       prioUndef;

  assign bothRouted = HAS_L3 && irqToL3 && fiqToL3;
  assign prioUndef  = bothRouted && undefPrio;

  // Ordered permission chain; the first matching condition wins.
  always_comb begin
    kindD = RSP_OK;
    tgtD  = 2'd0;
    unique case (reqLevel)
      2'd0: kindD = RSP_UNDEF;
      2'd1: begin
        if (prioUndef) begin
          kindD = RSP_UNDEF;
        end else if (!sreL1) begin
          kindD = RSP_TRAP; tgtD = 2'd1;
        end else if (l2Enabled && l2TrapCtl) begin
          kindD = RSP_TRAP; tgtD = 2'd2;
        end else if (l2Enabled && (l2FiqRoute || l2IrqRoute)) begin
          kindD = RSP_VIRT;
        end else if (bothRouted) begin
          if (dbgUndef) kindD = RSP_UNDEF;
          else begin kindD = RSP_TRAP; tgtD = 2'd3; end
        end
      end
      2'd2: begin
        if (prioUndef) begin
          kindD = RSP_UNDEF;
        end else if (!sreL2) begin
          kindD = RSP_TRAP; tgtD = 2'd2;
        end else if (bothRouted) begin
          if (dbgUndef) kindD = RSP_UNDEF;
          else begin kindD = RSP_TRAP; tgtD = 2'd3; end
        end
      end
      default: begin
        if (!HAS_L3) begin
          kindD = RSP_UNDEF;
        end else if (!sreL3) begin
          kindD = RSP_TRAP; tgtD = 2'd3;
        end
      end
    endcase
  end

  always_comb begin
    strobe.accept   = reqValid;
    strobe.okAccess = reqValid && (kindD == RSP_OK);
    strobe.wrEn     = reqValid && (kindD == RSP_OK) && reqWrite;
    strobe.bankSel  = reqNonSecure;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspKind     <= RSP_OK;
      rspTarget   <= 2'd0;
      rspSyndrome <= 6'd0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspKind     <= kindD;
        rspTarget   <= tgtD;
        rspSyndrome <= (kindD == RSP_TRAP) ? TRAP_CLASS : 6'd0;
      end
    end
  end
endmodule

// File: rtl/bca_bank.sv
module bca_bank
  import bca_pkg::*;
#(
  parameter bit HAS_L3      = 1'b1,
  parameter bit EXT_RANGE   = 1'b1,
  parameter bit WIDE_TARGET = 1'b0,
  parameter bit AFF3_OK     = 1'b1,
  parameter bit LOCAL_SERR  = 1'b0,
  parameter bit ID24        = 1'b1,
  parameter int PRI_BITS    = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t strobe,
  input  logic        secDisable,
  input  logic [63:0] wrData,
  output logic [63:0] rdData
);
  localparam int NB = HAS_L3 ? 2 : 1;
  localparam logic [2:0] PRI_FIELD = 3'(PRI_BITS - 1);
  localparam logic [2:0] ID_FIELD  = ID24 ? 3'b001 : 3'b000;
  localparam logic [63:0] CAP_VALUE =
      (64'(EXT_RANGE) << 19) | (64'(WIDE_TARGET) << 18) |
      (64'(AFF3_OK) << 15) | (64'(LOCAL_SERR) << 14) |
      (64'(ID_FIELD) << 11) | (64'(PRI_FIELD) << 8);

  // Stored bits per bank: [2] distribution hint, [1] EOI mode, [0] grouping.
  logic [2:0] bankQ [NB];
  logic [2:0] newBits;
  logic [2:0] wrMask;
  logic [2:0] selBits;
  logic       guardedWr;
  logic       unusedWrBits;

  assign guardedWr    = !HAS_L3 || secDisable;
  assign wrMask       = {guardedWr, 1'b1, guardedWr};
  assign newBits      = {wrData[6], wrData[1], wrData[0]};
  assign unusedWrBits = ^{wrData[63:7], wrData[5:2]};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    if (NB == 2) begin : g_sel
      assign hit = (strobe.bankSel == b[0]);
    end else begin : g_one
      assign hit = 1'b1;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankQ[b] <= 3'b000;
      else if (strobe.wrEn && hit)
        bankQ[b] <= (bankQ[b] & ~wrMask) | (newBits & wrMask);
    end
  end

  if (NB == 2) begin : g_rd2
    assign selBits = strobe.bankSel ? bankQ[1] : bankQ[0];
  end else begin : g_rd1
    assign selBits = bankQ[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= 64'd0;
    else if (strobe.accept)
      rdData <= strobe.okAccess
          ? (CAP_VALUE | {57'd0, selBits[2], 4'd0, selBits[1], selBits[0]})
          : 64'd0;
  end
endmodule

// File: rtl/bca_top.sv
module bca_top #(
  parameter bit HAS_L3      = 1'b1,
  parameter bit EXT_RANGE   = 1'b1,
  parameter bit WIDE_TARGET = 1'b0,
  parameter bit AFF3_OK     = 1'b1,
  parameter bit LOCAL_SERR  = 1'b0,
  parameter bit ID24        = 1'b1,
  parameter int PRI_BITS    = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqLevel,
  input  logic        reqNonSecure,
  input  logic [63:0] wrData,
  input  logic        secDisable,
  input  logic        sreL1,
  input  logic        sreL2,
  input  logic        sreL3,
  input  logic        l2Enabled,
  input  logic        l2TrapCtl,
  input  logic        l2FiqRoute,
  input  logic        l2IrqRoute,
  input  logic        irqToL3,
  input  logic        fiqToL3,
  input  logic        dbgUndef,
  input  logic        undefPrio,
  output logic        rspValid,
  output logic [1:0]  rspKind,
  output logic [1:0]  rspTarget,
  output logic [5:0]  rspSyndrome,
  output logic [63:0] rdData
);
  bca_pkg::bankStrobe_t strobe;

  bca_decide #(.HAS_L3(HAS_L3)) decide_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLevel(reqLevel), .reqNonSecure(reqNonSecure),
    .sreL1(sreL1), .sreL2(sreL2), .sreL3(sreL3),
    .l2Enabled(l2Enabled), .l2TrapCtl(l2TrapCtl),
    .l2FiqRoute(l2FiqRoute), .l2IrqRoute(l2IrqRoute),
    .irqToL3(irqToL3), .fiqToL3(fiqToL3), .dbgUndef(dbgUndef),
    .undefPrio(undefPrio), .strobe(strobe), .rspValid(rspValid),
    .rspKind(rspKind), .rspTarget(rspTarget), .rspSyndrome(rspSyndrome)
  );

  bca_bank #(
    .HAS_L3(HAS_L3), .EXT_RANGE(EXT_RANGE), .WIDE_TARGET(WIDE_TARGET),
    .AFF3_OK(AFF3_OK), .LOCAL_SERR(LOCAL_SERR), .ID24(ID24),
    .PRI_BITS(PRI_BITS)
  ) bank_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .secDisable(secDisable),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/bca_chk.sv
module bca_chk #(
  parameter bit HAS_L3   = 1'b1,
  parameter int PRI_BITS = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  reqLevel,
  input logic        sreL3,
  input logic        rspValid,
  input logic [1:0]  rspKind,
  input logic [1:0]  rspTarget,
  input logic [5:0]  rspSyndrome,
  input logic [63:0] rdData
);
  localparam logic [63:0] RSVD_MASK = 64'hFFFF_FFFF_FFF3_00BC;
  localparam logic [2:0]  PRI_FIELD = 3'(PRI_BITS - 1);

  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r11_rsp_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  a_r6_l0_undef: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqLevel == 2'd0 |=> rspKind == 2'd2);
  a_r8_l3_trap: assert property (@(posedge clk) disable iff (!rstN)
    HAS_L3 && reqValid && reqLevel == 2'd3 && !sreL3 |=>
      rspKind == 2'd3 && rspTarget == 2'd3);
  a_r9_trap_class: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspKind == 2'd3 |-> rspSyndrome == 6'h18);
  a_r9_no_class: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspKind != 2'd3 |-> rspSyndrome == 6'd0);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rdData & RSVD_MASK) == 64'd0);
  a_r2_pri_field: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspKind == 2'd0 |-> rdData[10:8] == PRI_FIELD);
endmodule

bind bca_top bca_chk #(.HAS_L3(HAS_L3), .PRI_BITS(PRI_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel),
  .sreL3(sreL3), .rspValid(rspValid), .rspKind(rspKind),
  .rspTarget(rspTarget), .rspSyndrome(rspSyndrome), .rdData(rdData)
);

// File: tb/bca_top_tb_top.sv
`timescale 1ns/1ps
module bca_top_tb_top;
  localparam logic [63:0] CAP = (64'd1 << 19) | (64'd1 << 15) |
                                (64'd1 << 11) | (64'd4 << 8);
  localparam logic [1:0] K_OK = 2'd0, K_VIRT = 2'd1, K_UNDEF = 2'd2, K_TRAP = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqNonSecure = 0;
  logic [1:0] reqLevel = 0;
  logic [63:0] wrData = 0;
  logic secDisable = 0, sreL1 = 1, sreL2 = 1, sreL3 = 1;
  logic l2Enabled = 0, l2TrapCtl = 0, l2FiqRoute = 0, l2IrqRoute = 0;
  logic irqToL3 = 0, fiqToL3 = 0, dbgUndef = 0, undefPrio = 0;
  logic rspValid;
  logic [1:0] rspKind, rspTarget;
  logic [5:0] rspSyndrome;
  logic [63:0] rdData;

  int vectors = 0;
  int errors = 0;
  logic mCbpr [2];
  logic mEoi [2];
  logic mHint [2];

  always #2.5 clk = ~clk;

  bca_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLevel(reqLevel), .reqNonSecure(reqNonSecure), .wrData(wrData),
    .secDisable(secDisable), .sreL1(sreL1), .sreL2(sreL2), .sreL3(sreL3),
    .l2Enabled(l2Enabled), .l2TrapCtl(l2TrapCtl), .l2FiqRoute(l2FiqRoute),
    .l2IrqRoute(l2IrqRoute), .irqToL3(irqToL3), .fiqToL3(fiqToL3),
    .dbgUndef(dbgUndef), .undefPrio(undefPrio), .rspValid(rspValid),
    .rspKind(rspKind), .rspTarget(rspTarget), .rspSyndrome(rspSyndrome),
    .rdData(rdData)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expVal(input logic ns);
    return CAP | {57'd0, mHint[ns], 4'd0, mEoi[ns], mCbpr[ns]};
  endfunction

  task automatic clearCtx();
    sreL1 = 1; sreL2 = 1; sreL3 = 1; l2Enabled = 0; l2TrapCtl = 0;
    l2FiqRoute = 0; l2IrqRoute = 0; irqToL3 = 0; fiqToL3 = 0;
    dbgUndef = 0; undefPrio = 0;
  endtask

  // One access; checks kind, target, syndrome and data; updates the model on OK writes.
  task automatic access(input string req, input logic w, input logic [1:0] lvl,
                        input logic ns, input logic [63:0] d,
                        input logic [1:0] expKind, input logic [1:0] expTgt);
    logic [63:0] expRd;
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqLevel = lvl; reqNonSecure = ns; wrData = d;
    expRd = (expKind == K_OK) ? expVal(ns) : 64'd0;
    @(negedge clk);
    reqValid = 0;
    check({req, " valid"}, {63'd0, rspValid}, 64'd1);
    check({req, " kind"}, {62'd0, rspKind}, {62'd0, expKind});
    check({req, " target"}, {62'd0, rspTarget}, {62'd0, expTgt});
    check({req, " syndrome"}, {58'd0, rspSyndrome},
          (expKind == K_TRAP) ? 64'h18 : 64'd0);
    check({req, " rdData"}, rdData, expRd);
    if (expKind == K_OK && w) begin
      mEoi[ns] = d[1];
      if (secDisable) begin mHint[ns] = d[6]; mCbpr[ns] = d[0]; end
    end
  endtask

  task automatic readBack(input string req, input logic ns);
    logic [63:0] saved;
    saved = {sreL1, sreL2, sreL3, l2Enabled, l2TrapCtl, l2FiqRoute, l2IrqRoute,
             irqToL3, fiqToL3, dbgUndef, undefPrio, 53'd0};
    clearCtx();
    access(req, 1'b0, 2'd3, ns, 64'd0, K_OK, 2'd0);
    {sreL1, sreL2, sreL3, l2Enabled, l2TrapCtl, l2FiqRoute, l2IrqRoute,
     irqToL3, fiqToL3, dbgUndef, undefPrio} = saved[63:53];
  endtask

  task automatic tReset();
    check("R11 idle after reset", {63'd0, rspValid}, 64'd0);
    readBack("R2 R4 R5 reset secure", 1'b0);
    readBack("R2 R4 R5 reset non-secure", 1'b1);
    @(negedge clk);
    check("R11 single-cycle valid", {63'd0, rspValid}, 64'd0);
  endtask

  task automatic tMaskOpen();
    secDisable = 1;
    access("R1 R2 R5 all-ones write ns", 1'b1, 2'd3, 1'b1, '1, K_OK, 2'd0);
    readBack("R1 R2 R5 readback ns", 1'b1);
    check("R5 hint and grouping set", rdData & 64'h43, 64'h43);
    readBack("R3 secure untouched", 1'b0);
    check("R3 secure still reset", rdData, CAP);
    access("R3 write secure 0x2", 1'b1, 2'd2, 1'b0, 64'h2, K_OK, 2'd0);
    readBack("R3 R4 secure eoi", 1'b0);
    readBack("R3 ns unchanged", 1'b1);
  endtask

  task automatic tMaskClosed();
    secDisable = 0;
    access("R5 guarded zero write ns", 1'b1, 2'd1, 1'b1, 64'd0, K_OK, 2'd0);
    readBack("R4 R5 ns after guarded write", 1'b1);
    check("R5 bits 6,0 held R4 bit1 cleared", rdData & 64'h43, 64'h41);
    access("R5 guarded set secure", 1'b1, 2'd3, 1'b0, 64'h41, K_OK, 2'd0);
    readBack("R5 secure guarded", 1'b0);
    check("R5 secure bits 6,0 still 0", rdData & 64'h41, 64'h0);
  endtask

  task automatic tLevel0();
    access("R6 level0 read", 1'b0, 2'd0, 1'b0, 64'd0, K_UNDEF, 2'd0);
    access("R6 level0 write", 1'b1, 2'd0, 1'b1, 64'h0, K_UNDEF, 2'd0);
    readBack("R6 R11 no change after level0 write", 1'b1);
  endtask

  task automatic tLevel1();
    // Stack every condition and peel off one at a time.
    secDisable = 1;
    sreL1 = 0; l2Enabled = 1; l2TrapCtl = 1; l2IrqRoute = 1; irqToL3 = 1; fiqToL3 = 1;
    access("R7 sre off first", 1'b1, 2'd1, 1'b0, 64'h43, K_TRAP, 2'd1);
    readBack("R11 trapped write no change", 1'b0);
    sreL1 = 1;
    access("R7 trap control", 1'b1, 2'd1, 1'b0, 64'h43, K_TRAP, 2'd2);
    l2TrapCtl = 0;
    access("R7 irq route virtual", 1'b1, 2'd1, 1'b0, 64'h43, K_VIRT, 2'd0);
    readBack("R11 virtual write no change", 1'b0);
    l2IrqRoute = 0; l2FiqRoute = 1;
    access("R7 fiq route virtual", 1'b0, 2'd1, 1'b0, 64'h0, K_VIRT, 2'd0);
    l2Enabled = 0;
    access("R7 both routed trap l3", 1'b0, 2'd1, 1'b0, 64'h0, K_TRAP, 2'd3);
    dbgUndef = 1;
    access("R7 both routed debug undef", 1'b0, 2'd1, 1'b0, 64'h0, K_UNDEF, 2'd0);
    fiqToL3 = 0;
    access("R7 single route ok", 1'b1, 2'd1, 1'b0, 64'h43, K_OK, 2'd0);
    readBack("R7 ok write landed", 1'b0);
    clearCtx();
  endtask

  task automatic tLevel2();
    sreL2 = 0; irqToL3 = 1; fiqToL3 = 1; l2TrapCtl = 1; l2Enabled = 1; sreL1 = 0;
    access("R8 l2 sre off", 1'b0, 2'd2, 1'b1, 64'h0, K_TRAP, 2'd2);
    sreL2 = 1;
    access("R8 l2 both routed trap", 1'b0, 2'd2, 1'b1, 64'h0, K_TRAP, 2'd3);
    dbgUndef = 1;
    access("R8 l2 debug undef", 1'b0, 2'd2, 1'b1, 64'h0, K_UNDEF, 2'd0);
    irqToL3 = 0;
    access("R8 l2 ok", 1'b0, 2'd2, 1'b1, 64'h0, K_OK, 2'd0);
    clearCtx();
    sreL3 = 0; irqToL3 = 1; fiqToL3 = 1; undefPrio = 1;
    access("R8 l3 sre off", 1'b1, 2'd3, 1'b1, 64'h0, K_TRAP, 2'd3);
    sreL3 = 1;
    access("R8 l3 ok despite routing", 1'b0, 2'd3, 1'b1, 64'h0, K_OK, 2'd0);
    clearCtx();
  endtask

  task automatic tOverride();
    sreL1 = 0; sreL2 = 0; l2Enabled = 1; l2TrapCtl = 1;
    irqToL3 = 1; fiqToL3 = 1; undefPrio = 1;
    access("R10 l1 override", 1'b1, 2'd1, 1'b0, 64'h0, K_UNDEF, 2'd0);
    access("R10 l2 override", 1'b1, 2'd2, 1'b0, 64'h0, K_UNDEF, 2'd0);
    readBack("R10 no change", 1'b0);
    fiqToL3 = 0;
    access("R10 needs both routed", 1'b0, 2'd1, 1'b0, 64'h0, K_TRAP, 2'd1);
    clearCtx();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin mCbpr[i] = 0; mEoi[i] = 0; mHint[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tMaskOpen();
    tMaskClosed();
    tLevel0();
    tLevel1();
    tLevel2();
    tOverride();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule